// File: doc/BRIEF.md
# Selectable Delay-Line Audio Effect Unit

This block processes a stream of 12-bit two's-complement audio samples. Every accepted sample goes into a 4096-entry circular history held in one RAM, with one write port and one read port. Four effect datapaths run on every sample: echo, chorus, phaser and flanger. Each one fetches an older sample from the history at its own tap distance. It halves that sample with an arithmetic shift, then adds it to the newest sample or subtracts it. The sum is clamped to the 12-bit range.

The echo tap is a fixed distance. The chorus, flanger and phaser taps sweep along a triangular path. The tap index of each swept effect moves one step per accepted sample. All four results exist for every sample. A registered multiplexer drives out the one chosen by the select value that came in with the sample.

The single RAM read port is shared in time. After a sample is accepted, the unit reads the four taps over four cycles. It presents the result six cycles after the accepting edge. Samples must therefore be at least seven cycles apart. A strobe that arrives while the unit is busy is dropped. The RAM is not cleared at reset. Instead, the output is held at zero until the history has filled.

Top module: `dly_fx_unit`

## Requirements
- R1: Each output equals sat(x + (t >>> 1)), or sat(x - (t >>> 1)) for the phaser. Here x is the current sample, t is the sample accepted d samples earlier, and both are read as 12-bit two's-complement values.
- R2: The select value captured with the sample picks the output: 0 = echo, 1 = chorus, 2 = phaser, 3 = flanger.
- R3: The echo tap distance d is fixed at 3000 samples.
- R4: The swept distances are tri(i, L) = (i < L/2 ? i : L-1-i) plus a base. The chorus uses base 1200 with L = 801, the flanger base 8 with L = 400, and the phaser base 40 with L = 400.
- R5: All three sweep indices start at 0, advance by one on every accepted sample whatever the select value, and wrap to 0 after L-1.
- R6: A sum or difference outside -2048..2047 is clamped to the nearest bound.
- R7: A strobe sampled at clock edge E gives smp_valid_o high for exactly the one cycle after edge E+6.
- R8: A strobe that falls in the six cycles after an accepted one is ignored: nothing is written to the history, no output is produced, and the sweep does not advance.
- R9: During reset, smp_valid_o and smp_o are 0. The write pointer, sweep indices and fill count restart from zero.
- R10: The outputs for the first 4095 accepted samples after reset are 0. From the 4096th sample onward, the outputs follow R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Input sample strobe |
| smp_i | input | 12 | Input sample, two's complement |
| fx_sel_i | input | 2 | Effect select, captured with the sample |
| smp_o | output | 12 | Processed sample, registered |
| smp_valid_o | output | 1 | One-cycle flag marking smp_o |

## Verification
Random full-range samples with a random select on each one exercise all four tap paths and the add/subtract choice. A wrong tap distance, a wrong sweep phase or a mis-routed select therefore shows up as a wrong value at once. Long constant runs at +2047 and -2048 drive echo, chorus and flanger into both clamp bounds. The same runs make the phaser land on exact in-range values, which separates the clamp from the subtraction. Strobes injected while the unit is busy must leave both the history and the sweep untouched, and later outputs depend on both. A warm-up phase of random data checks that the output stays zero until the history is full.

// File: rtl/dly_fx_pkg.sv
package dly_fx_pkg;
  typedef enum logic [1:0] {
    FX_ECHO    = 2'd0,
    FX_CHORUS  = 2'd1,
    FX_PHASER  = 2'd2,
    FX_FLANGER = 2'd3
  } fx_sel_e;

  localparam int unsigned NUM_FX = 4;
  localparam int unsigned PH_W   = 3;

  // sequencer phases: 1..4 issue reads, 2..5 load mixers, 6 drives output
  localparam logic [PH_W-1:0] PH_IDLE  = 3'd0;
  localparam logic [PH_W-1:0] PH_RD_LO = 3'd1;
  localparam logic [PH_W-1:0] PH_RD_HI = 3'd4;
  localparam logic [PH_W-1:0] PH_OUT   = 3'd6;
endpackage

// File: rtl/dly_ram.sv
module dly_ram #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/fx_tap_gen.sv
module fx_tap_gen #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned BASE   = 8,
  parameter int unsigned LEN    = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] dly_o
);
  localparam int unsigned IW   = (LEN > 1) ? $clog2(LEN) : 1;
  localparam int unsigned HALF = LEN / 2;

  logic [IW-1:0] idx_q;
  int unsigned   tri_v;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
    end else if (adv_i) begin
      if (idx_q == IW'(LEN - 1)) idx_q <= '0;
      else                       idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    if (int'(idx_q) < int'(HALF)) tri_v = int'(idx_q);
    else                          tri_v = (LEN - 1) - int'(idx_q);
    dly_o = ADDR_W'(BASE + tri_v);
  end

  // R5: index steps by one or wraps to zero
  a_r5_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> (idx_q == '0) || (idx_q == $past(idx_q) + 1'b1));

  // R4: a tap of zero would read the slot being written
  a_r4_dly_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dly_o != '0);
endmodule

// File: rtl/fx_mix.sv
module fx_mix #(
  parameter int unsigned DATA_W = 12,
  parameter bit          SUB    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] tap_i,
  output logic [DATA_W-1:0] y_o
);
  localparam logic [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [DATA_W:0] x_ext, half_ext, sum;
  logic [DATA_W-1:0]      sat;

  always_comb begin
    x_ext    = {x_i[DATA_W-1], x_i};
    half_ext = {tap_i[DATA_W-1], tap_i[DATA_W-1], tap_i[DATA_W-1:1]};
    sum      = SUB ? (x_ext - half_ext) : (x_ext + half_ext);
    if (sum[DATA_W] != sum[DATA_W-1]) sat = sum[DATA_W] ? S_MIN : S_MAX;
    else                              sat = sum[DATA_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   y_o <= '0;
    else if (ld_i) y_o <= sat;
  end

  // R6: operands pulling the same way never wrap to the opposite sign
  a_r6_no_wrap_pos: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && !x_i[DATA_W-1] && (tap_i[DATA_W-1] == SUB) |=> !y_o[DATA_W-1]);
  a_r6_no_wrap_neg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i && x_i[DATA_W-1] && (tap_i[DATA_W-1] != SUB) |=> y_o[DATA_W-1]);
endmodule

// File: rtl/dly_fx_unit.sv
module dly_fx_unit
  import dly_fx_pkg::*;
#(
  parameter int unsigned DATA_W       = 12,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned ECHO_DLY     = 3000,
  parameter int unsigned CHORUS_BASE  = 1200,
  parameter int unsigned CHORUS_LEN   = 801,
  parameter int unsigned PHASER_BASE  = 40,
  parameter int unsigned PHASER_LEN   = 400,
  parameter int unsigned FLANGER_BASE = 8,
  parameter int unsigned FLANGER_LEN  = 400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_valid_i,
  input  logic [DATA_W-1:0] smp_i,
  input  logic [1:0]        fx_sel_i,
  output logic [DATA_W-1:0] smp_o,
  output logic              smp_valid_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned CNT_W = ADDR_W + 1;

  logic [PH_W-1:0]   ph_q;
  logic [ADDR_W-1:0] wr_ptr_q, base_q;
  logic [DATA_W-1:0] x_q;
  fx_sel_e           sel_q;
  logic [CNT_W-1:0]  fill_q;
  logic              full;
  logic              accept, rd_en, sweep_adv;
  logic [1:0]        slot;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W-1:0] dly [NUM_FX];
  logic [DATA_W-1:0] fx_y [NUM_FX];

  assign accept    = smp_valid_i && (ph_q == PH_IDLE);
  assign rd_en     = (ph_q >= PH_RD_LO) && (ph_q <= PH_RD_HI);
  assign slot      = 2'(ph_q - PH_RD_LO);
  assign rd_addr   = base_q - dly[slot];
  assign sweep_adv = (ph_q == PH_OUT);
  assign full      = (fill_q == CNT_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_IDLE;
      wr_ptr_q <= '0;
      base_q   <= '0;
      x_q      <= '0;
      sel_q    <= FX_ECHO;
      fill_q   <= '0;
    end else begin
      if (accept) begin
        ph_q     <= PH_RD_LO;
        base_q   <= wr_ptr_q;
        wr_ptr_q <= wr_ptr_q + 1'b1;
        x_q      <= smp_i;
        sel_q    <= fx_sel_e'(fx_sel_i);
        if (!full) fill_q <= fill_q + 1'b1;
      end else if (ph_q == PH_OUT) begin
        ph_q <= PH_IDLE;
      end else if (ph_q != PH_IDLE) begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  dly_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ram_i (
    .clk_i   (clk_i),
    .we_i    (accept),
    .waddr_i (wr_ptr_q),
    .wdata_i (smp_i),
    .re_i    (rd_en),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  for (genvar k = 0; k < NUM_FX; k++) begin : g_fx
    localparam int unsigned K_BASE = (k == int'(FX_ECHO))   ? ECHO_DLY    :
                                     (k == int'(FX_CHORUS)) ? CHORUS_BASE :
                                     (k == int'(FX_PHASER)) ? PHASER_BASE : FLANGER_BASE;
    localparam int unsigned K_LEN  = (k == int'(FX_ECHO))   ? 1           :
                                     (k == int'(FX_CHORUS)) ? CHORUS_LEN  :
                                     (k == int'(FX_PHASER)) ? PHASER_LEN  : FLANGER_LEN;

    fx_tap_gen #(.ADDR_W(ADDR_W), .BASE(K_BASE), .LEN(K_LEN)) tap_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (sweep_adv),
      .dly_o  (dly[k])
    );

    fx_mix #(.DATA_W(DATA_W), .SUB(k == int'(FX_PHASER))) mix_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .ld_i   (ph_q == PH_W'(k + 2)),
      .x_i    (x_q),
      .tap_i  (rd_data),
      .y_o    (fx_y[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_o       <= '0;
      smp_valid_o <= 1'b0;
    end else begin
      smp_valid_o <= (ph_q == PH_OUT);
      if (ph_q == PH_OUT) smp_o <= full ? fx_y[sel_q] : '0;
    end
  end

  // R7: result pulse is one cycle wide
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |=> !smp_valid_o);
  // R7: result follows its strobe by a fixed latency
  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o |-> $past(smp_valid_i, 7));
  // R8: a strobe while busy does not move the write pointer
  a_r8_busy_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i && (ph_q != PH_IDLE) |=> $stable(wr_ptr_q));
  // R10: zero output until the history is full
  a_r10_warmup_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_o && (fill_q != CNT_W'(DEPTH)) |-> (smp_o == '0));
endmodule

// File: tb/dly_fx_unit_tb_top.sv
module dly_fx_unit_tb_top;
  localparam int ECHO_D = 3000;
  localparam int CH_B = 1200, CH_L = 801;
  localparam int PH_B = 40,   PH_L = 400;
  localparam int FL_B = 8,    FL_L = 400;
  localparam int FILL = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic [11:0] smp = '0;
  logic [1:0]  sel = '0;
  logic [11:0] smp_o;
  logic        smp_valid_o;

  int errs = 0, checks = 0;
  int hist [0:19999];
  int n = 0, ci = 0, pi = 0, fi = 0;

  always #2ns clk = ~clk;

  dly_fx_unit dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .smp_valid_i (vld_i),
    .smp_i       (smp),
    .fx_sel_i    (sel),
    .smp_o       (smp_o),
    .smp_valid_o (smp_valid_o)
  );

  task automatic check(bit ok, string tag, int got, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: got %0d expected %0d at sample %0d", tag, got, exp, n);
    end
  endtask

  function automatic int tri_f(int i, int l);
    return (i < l / 2) ? i : l - 1 - i;
  endfunction

  function automatic int sat12(int v);
    if (v > 2047)  return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  // R1 R2 R3 R4 model; R10 warm-up zero
  function automatic int model(int x, int s, int idx);
    int d, t;
    if (idx < FILL - 1) return 0;
    case (s)
      0:       d = ECHO_D;
      1:       d = CH_B + tri_f(ci, CH_L);
      2:       d = PH_B + tri_f(pi, PH_L);
      default: d = FL_B + tri_f(fi, FL_L);
    endcase
    t = hist[idx - d];
    return (s == 2) ? sat12(x - (t >>> 1)) : sat12(x + (t >>> 1));
  endfunction

  task automatic send(int x, int s, bit busy_poke);
    int exp_v, got;
    bit pulse_ok = 1'b1;
    string tag;
    @(negedge clk);
    if (smp_valid_o) pulse_ok = 1'b0;
    vld_i = 1'b1; smp = 12'(x); sel = 2'(s);
    @(negedge clk);
    vld_i = 1'b0;
    hist[n] = x;
    exp_v = model(x, s, n);
    for (int c = 1; c <= 5; c++) begin
      if (busy_poke && c == 2) begin
        vld_i = 1'b1; smp = ~smp; sel = ~sel;  // R8: must be dropped
      end else begin
        vld_i = 1'b0;
      end
      @(negedge clk);
      if (smp_valid_o) pulse_ok = 1'b0;
    end
    vld_i = 1'b0;
    @(negedge clk);
    check(smp_valid_o && pulse_ok, "R7/R8 valid pulse", int'(smp_valid_o), 1);
    got = int'($signed(smp_o));
    if (n < FILL - 1)                         tag = "R10 warm-up";
    else if (exp_v == 2047 || exp_v == -2048) tag = "R6 clamp";
    else if (s == 0)                          tag = "R1/R2/R3 echo";
    else                                      tag = "R1/R2/R4 swept";
    check(got == exp_v, tag, got, exp_v);
    // R5: every sweep advances on each accepted sample
    n++;
    ci = (ci + 1) % CH_L;
    pi = (pi + 1) % PH_L;
    fi = (fi + 1) % FL_L;
  endtask

  function automatic int rnd_smp();
    int r = int'($urandom_range(0, 9));
    if (r == 0) return 2047;
    if (r == 1) return -2048;
    return int'($urandom_range(0, 4095)) - 2048;
  endfunction

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check(smp_valid_o == 1'b0, "R9 reset valid", int'(smp_valid_o), 0);
    check(smp_o == '0, "R9 reset data", int'(smp_o), 0);
    rst_n = 1'b1;
    for (int i = 0; i < FILL - 1; i++)
      send(rnd_smp(), int'($urandom_range(0, 3)), (i % 97) == 5);
    for (int i = 0; i < 2500; i++)
      send(rnd_smp(), int'($urandom_range(0, 3)), (i % 50) == 7);
    for (int i = 0; i < 3100; i++) send(2047, i % 4, 1'b0);
    for (int i = 0; i < 3100; i++) send(-2048, i % 4, (i % 300) == 1);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule